// File: doc/BRIEF.md
# Serial Byte Buffer and Channel Router

This block is the buffering and status core that sits between a processor-side register port and a serial transceiver. It keeps two 16-entry byte queues: one for receive and one for transmit. A 2-bit channel-mode setting decides where each byte arriving from the serial side goes. The byte can go into the receive queue, into the transmit queue so that it is echoed back out, into both, or be dropped. The block builds a live status word from how full each queue is and from two programmable threshold levels. It also latches sticky interrupt causes for receive overrun and receive idle timeout, and drives one interrupt line through a mask.

Software uses a 32-bit port addressed by word index, with reads answered in the same cycle. The transceiver side pushes received bytes with a single-cycle strobe. `sin_ready` tells it whether the queues the current mode targets have room, but the strobe cannot be held back. Bytes to transmit leave on a valid/ready pair.

Top module: `uart_chan_core`

## Requirements
- R1: Each queue holds 16 bytes and releases them in arrival order, both on the data register read (receive) and on the `sout` interface (transmit).
- R2: Mode register (word 1, bits [1:0]) routes a serial byte: 0 to the receive queue, 1 to both queues, 2 to neither (byte accepted and discarded), 3 to the transmit queue only.
- R3: `sin_ready` is high exactly when every queue the current mode targets holds fewer than 16 bytes (always high in mode 2).
- R4: A strobed serial byte in mode 0 or 1 that finds the receive queue full is not stored there, and sets sticky bit 0 of the interrupt status register (word 3).
- R5: Status (word 6, read-only) bits: [0] receive count >= receive threshold (word 4, reset 8), [1] receive empty, [2] receive full, [3] transmit empty, [4] transmit full, [5] transmit count >= transmit threshold (word 5, reset 8); other bits zero.
- R6: A read of the data register (word 7) returns and removes the oldest receive byte only when control bit 2 is 1 and control bit 3 is 0; otherwise, or when empty, it returns 0 and removes nothing.
- R7: A write to the data register queues `wdata[7:0]` for transmit only when control bit 4 is 1 and bit 5 is 0, the transmit queue is not full, and no serial byte targets the transmit queue in that cycle (serial side has priority); otherwise the write is dropped.
- R8: Writing control (word 0) with bit 0 set empties the receive queue, and with bit 1 set empties the transmit queue; both bits read back as 0.
- R9: Control resets to 0x00000128. The mode, mask and status-cause registers reset to 0. Every word index other than 0 to 7 reads as 0.
- R10: A receive idle timeout sets sticky interrupt status bit 1 TIMEOUT_CYC cycles after the last byte accepted into the receive queue, provided no further byte arrives in between.
- R11: `irq` is the OR of the interrupt status bits ANDed with the mask (word 2, bits [1:0]). Writing 1 to an interrupt status bit clears it, and a new event in the same cycle wins.
- R12: `sout_valid` is high while the transmit queue is non-empty, `sout_data` shows its oldest byte, and a byte is removed on each cycle with `sout_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle as the read |
| sin_valid | input | 1 | Serial-side byte strobe |
| sin_data | input | 8 | Serial-side byte |
| sin_ready | output | 1 | Targeted queues have room |
| sout_valid | output | 1 | Transmit byte available |
| sout_data | output | 8 | Oldest transmit byte |
| sout_ready | input | 1 | Transmitter takes the byte |
| irq | output | 1 | Masked interrupt |

## Verification
Read data, `sin_ready`, `sout_valid`/`sout_data` and `irq` are combinational from state, so they are due in the cycle of the access. Queue contents, the sticky bits and status change at the next rising edge. The timeout bit appears TIMEOUT_CYC edges after the edge that accepted the last byte. The bench drives inputs at the falling edge, compares every output against its behavioural model one time unit later, and only then advances the model at the rising edge, so each result is checked in the exact cycle it is due.

// File: rtl/uartq_pkg.sv
package uartq_pkg;
   // word indices of the register port
   localparam int unsigned RG_CTRL   = 0;
   localparam int unsigned RG_MODE   = 1;
   localparam int unsigned RG_IMASK  = 2;
   localparam int unsigned RG_ISTAT  = 3;
   localparam int unsigned RG_RXTRIG = 4;
   localparam int unsigned RG_TXTRIG = 5;
   localparam int unsigned RG_STATUS = 6;
   localparam int unsigned RG_DATA   = 7;

   // control bit positions (reset value depends on them)
   localparam int unsigned CB_RXCLR = 0;
   localparam int unsigned CB_TXCLR = 1;
   localparam int unsigned CB_RXON  = 2;
   localparam int unsigned CB_RXOFF = 3;
   localparam int unsigned CB_TXON  = 4;
   localparam int unsigned CB_TXOFF = 5;
   localparam logic [31:0] CTRL_RST = 32'h0000_0128;

   // sticky cause bits
   localparam int unsigned IB_OVR = 0;
   localparam int unsigned IB_TMO = 1;

   typedef enum logic [1:0] {
      CHM_NORMAL = 2'd0,
      CHM_ECHO   = 2'd1,
      CHM_LOCAL  = 2'd2,
      CHM_REMOTE = 2'd3
   } chmode_e;
endpackage

// File: rtl/uartq_ring.sv
module uartq_ring #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned DEPTH = 16,
   localparam int unsigned PW = $clog2(DEPTH),
   localparam int unsigned CW = PW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic [CW-1:0]    count,
   output logic             full,
   output logic             empty
);
   if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
      $error("uartq_ring: DEPTH must be a power of two, at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PW-1:0]    wptr;
   logic [PW-1:0]    rptr;
   logic             do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   // oldest entry sits count places behind the write pointer
   assign rptr    = wptr - count[PW-1:0];
   assign dout    = mem[rptr];

   always_ff @(posedge clk) begin
      if (do_push && !clr) mem[wptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         count <= '0;
      end else if (clr) begin
         wptr  <= '0;
         count <= '0;
      end else begin
         if (do_push) wptr <= wptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   assert_push_counts_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !full && !pop && !clr) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/uartq_status.sv
module uartq_status #(
   parameter int unsigned CW = 5
) (
   input  logic [CW-1:0] rx_cnt,
   input  logic [CW-1:0] tx_cnt,
   input  logic [CW-1:0] rx_lvl,
   input  logic [CW-1:0] tx_lvl,
   input  logic          rx_full,
   input  logic          rx_empty,
   input  logic          tx_full,
   input  logic          tx_empty,
   output logic [31:0]   word
);
   always_comb begin
      word    = '0;
      word[0] = (rx_cnt >= rx_lvl);
      word[1] = rx_empty;
      word[2] = rx_full;
      word[3] = tx_empty;
      word[4] = tx_full;
      word[5] = (tx_cnt >= tx_lvl);
      assert_rx_not_both_R5: assert (!(word[1] && word[2]));
      assert_tx_not_both_R5: assert (!(word[3] && word[4]));
   end
endmodule

// File: rtl/uart_chan_core.sv
module uart_chan_core
   import uartq_pkg::*;
#(
   parameter int unsigned DEPTH       = 16,
   parameter int unsigned ADDR_W      = 6,
   parameter int unsigned TIMEOUT_CYC = 32,
   parameter int unsigned LVL_RST     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              sin_valid,
   input  logic [7:0]        sin_data,
   output logic              sin_ready,
   output logic              sout_valid,
   output logic [7:0]        sout_data,
   input  logic              sout_ready,
   output logic              irq
);
   localparam int unsigned CW  = $clog2(DEPTH) + 1;
   localparam int unsigned TOW = $clog2(TIMEOUT_CYC + 1);

   if (ADDR_W < 3) begin : g_bad_addr
      $error("uart_chan_core: ADDR_W too small for the register set");
   end
   if (TIMEOUT_CYC < 1) begin : g_bad_tmo
      $error("uart_chan_core: TIMEOUT_CYC must be at least 1");
   end
   if (LVL_RST > DEPTH) begin : g_bad_lvl
      $error("uart_chan_core: LVL_RST exceeds DEPTH");
   end

   logic [31:0]   ctrl_q;
   chmode_e       mode_q;
   logic [1:0]    imask_q, istat_q;
   logic [CW-1:0] rx_lvl_q, tx_lvl_q;
   logic [TOW-1:0] tmo_cnt;
   logic          tmo_arm;

   logic wr, rd, wr_ctrl, rx_clr, tx_clr;
   logic tgt_rx, tgt_tx, rx_on, tx_on;
   logic rx_push, rx_pop, tx_push, tx_pop, ser_tx, bus_tx;
   logic ovr_evt, tmo_evt, rx_acc;
   logic [7:0] rx_dout, tx_dout, tx_din;
   logic [CW-1:0] rx_cnt, tx_cnt;
   logic rx_full, rx_empty, tx_full, tx_empty;
   logic [31:0] stat_word;

   assign wr      = bus_sel && bus_we;
   assign rd      = bus_sel && !bus_we;
   assign wr_ctrl = wr && (bus_addr == ADDR_W'(RG_CTRL));
   assign rx_clr  = wr_ctrl && bus_wdata[CB_RXCLR];
   assign tx_clr  = wr_ctrl && bus_wdata[CB_TXCLR];
   assign rx_on   = ctrl_q[CB_RXON] && !ctrl_q[CB_RXOFF];
   assign tx_on   = ctrl_q[CB_TXON] && !ctrl_q[CB_TXOFF];

   assign tgt_rx    = (mode_q == CHM_NORMAL) || (mode_q == CHM_ECHO);
   assign tgt_tx    = (mode_q == CHM_ECHO) || (mode_q == CHM_REMOTE);
   assign sin_ready = (!tgt_rx || !rx_full) && (!tgt_tx || !tx_full);

   assign rx_push = sin_valid && tgt_rx && !rx_full;
   assign ovr_evt = sin_valid && tgt_rx && rx_full;
   assign rx_acc  = rx_push && !rx_clr;
   assign rx_pop  = rd && (bus_addr == ADDR_W'(RG_DATA)) && rx_on && !rx_empty;

   assign ser_tx  = sin_valid && tgt_tx;
   assign bus_tx  = wr && (bus_addr == ADDR_W'(RG_DATA)) && tx_on && !ser_tx;
   assign tx_push = ser_tx || bus_tx;
   assign tx_din  = ser_tx ? sin_data : bus_wdata[7:0];
   assign tx_pop  = sout_ready;

   uartq_ring #(.WIDTH(8), .DEPTH(DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(rx_push), .din(sin_data),
      .pop(rx_pop), .dout(rx_dout), .count(rx_cnt), .full(rx_full), .empty(rx_empty));

   uartq_ring #(.WIDTH(8), .DEPTH(DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .clr(tx_clr), .push(tx_push), .din(tx_din),
      .pop(tx_pop), .dout(tx_dout), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

   uartq_status #(.CW(CW)) u_stat (
      .rx_cnt(rx_cnt), .tx_cnt(tx_cnt), .rx_lvl(rx_lvl_q), .tx_lvl(tx_lvl_q),
      .rx_full(rx_full), .rx_empty(rx_empty), .tx_full(tx_full), .tx_empty(tx_empty),
      .word(stat_word));

   assign sout_valid = !tx_empty;
   assign sout_data  = tx_dout;

   // idle timer: restarted by every accepted receive byte
   assign tmo_evt = tmo_arm && (tmo_cnt == TOW'(1)) && !rx_acc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmo_cnt <= '0;
         tmo_arm <= 1'b0;
      end else if (rx_acc) begin
         tmo_cnt <= TOW'(TIMEOUT_CYC);
         tmo_arm <= 1'b1;
      end else if (tmo_arm) begin
         tmo_cnt <= tmo_cnt - 1'b1;
         if (tmo_cnt == TOW'(1)) tmo_arm <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= CTRL_RST;
         mode_q   <= CHM_NORMAL;
         imask_q  <= '0;
         istat_q  <= '0;
         rx_lvl_q <= CW'(LVL_RST);
         tx_lvl_q <= CW'(LVL_RST);
      end else begin
         if (wr_ctrl) ctrl_q <= bus_wdata & ~32'h3;
         if (wr && (bus_addr == ADDR_W'(RG_MODE)))   mode_q   <= chmode_e'(bus_wdata[1:0]);
         if (wr && (bus_addr == ADDR_W'(RG_IMASK)))  imask_q  <= bus_wdata[1:0];
         if (wr && (bus_addr == ADDR_W'(RG_RXTRIG))) rx_lvl_q <= bus_wdata[CW-1:0];
         if (wr && (bus_addr == ADDR_W'(RG_TXTRIG))) tx_lvl_q <= bus_wdata[CW-1:0];
         istat_q <= (istat_q & ~((wr && (bus_addr == ADDR_W'(RG_ISTAT))) ? bus_wdata[1:0] : 2'b00))
                  | {tmo_evt, ovr_evt};
      end
   end

   assign irq = |(istat_q & imask_q);

   always_comb begin
      bus_rdata = '0;
      if (rd) begin
         case (bus_addr)
            ADDR_W'(RG_CTRL):   bus_rdata = ctrl_q;
            ADDR_W'(RG_MODE):   bus_rdata = {30'd0, mode_q};
            ADDR_W'(RG_IMASK):  bus_rdata = {30'd0, imask_q};
            ADDR_W'(RG_ISTAT):  bus_rdata = {30'd0, istat_q};
            ADDR_W'(RG_RXTRIG): bus_rdata = 32'(rx_lvl_q);
            ADDR_W'(RG_TXTRIG): bus_rdata = 32'(tx_lvl_q);
            ADDR_W'(RG_STATUS): bus_rdata = stat_word;
            ADDR_W'(RG_DATA):   bus_rdata = rx_pop ? {24'd0, rx_dout} : 32'd0;
            default:            bus_rdata = '0;
         endcase
      end
   end

   assert_overrun_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_evt |=> istat_q[IB_OVR]);
   assert_timeout_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_evt |=> istat_q[IB_TMO]);
   assert_rx_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_clr |=> rx_empty);
   assert_tx_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_clr |=> tx_empty);
   assert_irq_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ((istat_q & imask_q) != 2'b00));
   assert_ready_rx_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sin_ready && tgt_rx) |-> !rx_full);
endmodule

// File: tb/sim_uart_chan_core.sv
module sim_uart_chan_core;
   localparam int DEPTH = 16;
   localparam int TMO   = 32;
   localparam int AW    = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_sel = 0, bus_we = 0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic sin_valid = 0;
   logic [7:0] sin_data = '0;
   logic sin_ready, sout_valid, sout_ready = 0, irq;
   logic [7:0] sout_data;

   always #5 clk = ~clk;

   uart_chan_core #(.DEPTH(DEPTH), .ADDR_W(AW), .TIMEOUT_CYC(TMO), .LVL_RST(8)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sin_valid(sin_valid), .sin_data(sin_data),
      .sin_ready(sin_ready), .sout_valid(sout_valid), .sout_data(sout_data),
      .sout_ready(sout_ready), .irq(irq));

   int checks = 0, fails = 0;
   bit done = 0;

   // reference model state
   logic [7:0] rxq[$], txq[$];
   logic [31:0] m_ctrl;
   logic [1:0] m_mode, m_mask, m_ist;
   int m_rlvl, m_tlvl, tleft;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
      end
   endtask

   function automatic bit trx(); return (m_mode == 0) || (m_mode == 1); endfunction
   function automatic bit ttx(); return (m_mode == 1) || (m_mode == 3); endfunction
   function automatic bit rxon(); return m_ctrl[2] && !m_ctrl[3]; endfunction
   function automatic bit txon(); return m_ctrl[4] && !m_ctrl[5]; endfunction

   function automatic logic [31:0] exp_stat();
      logic [31:0] s = '0;
      s[0] = rxq.size() >= m_rlvl;
      s[1] = rxq.size() == 0;
      s[2] = rxq.size() == DEPTH;
      s[3] = txq.size() == 0;
      s[4] = txq.size() == DEPTH;
      s[5] = txq.size() >= m_tlvl;
      return s;
   endfunction

   function automatic logic [31:0] exp_read(int a);
      case (a)
         0: return m_ctrl;
         1: return {30'd0, m_mode};
         2: return {30'd0, m_mask};
         3: return {30'd0, m_ist};
         4: return 32'(m_rlvl);
         5: return 32'(m_tlvl);
         6: return exp_stat();
         7: return (rxon() && rxq.size() > 0) ? {24'd0, rxq[0]} : 32'd0;
         default: return 32'd0;
      endcase
   endfunction

   task automatic model_reset();
      rxq.delete(); txq.delete();
      m_ctrl = 32'h128; m_mode = 0; m_mask = 0; m_ist = 0;
      m_rlvl = 8; m_tlvl = 8; tleft = 0;
   endtask

   task automatic model_step();
      bit wr = bus_sel && bus_we, rd = bus_sel && !bus_we;
      int a = int'(bus_addr);
      bit rxfull = rxq.size() == DEPTH, txfull = txq.size() == DEPTH;
      bit rxclr = wr && a == 0 && bus_wdata[0];
      bit txclr = wr && a == 0 && bus_wdata[1];
      bit tr = trx(), tt = ttx(), ron = rxon(), ton = txon();
      bit ovr = sin_valid && tr && rxfull;
      bit acc = sin_valid && tr && !rxfull && !rxclr;
      bit tmo = 0;
      bit txnonempty = txq.size() > 0;
      if (rxclr) rxq.delete();
      else begin
         if (rd && a == 7 && ron && rxq.size() > 0) void'(rxq.pop_front());
         if (sin_valid && tr && !rxfull) rxq.push_back(sin_data);
      end
      if (txclr) txq.delete();
      else begin
         if (sout_ready && txnonempty) void'(txq.pop_front());
         if (sin_valid && tt) begin
            if (!txfull) txq.push_back(sin_data);
         end else if (wr && a == 7 && ton && !txfull) txq.push_back(bus_wdata[7:0]);
      end
      if (acc) tleft = TMO;
      else if (tleft > 0) begin
         if (tleft == 1) tmo = 1;
         tleft--;
      end
      m_ist = (m_ist & ~((wr && a == 3) ? bus_wdata[1:0] : 2'b00)) | {tmo, ovr};
      if (wr && a == 0) m_ctrl = bus_wdata & ~32'h3;
      if (wr && a == 1) m_mode = bus_wdata[1:0];
      if (wr && a == 2) m_mask = bus_wdata[1:0];
      if (wr && a == 4) m_rlvl = int'(bus_wdata[4:0]);
      if (wr && a == 5) m_tlvl = int'(bus_wdata[4:0]);
   endtask

   // one clock: compare outputs mid-cycle, then advance model at the edge
   task automatic cyc();
      bit er;
      #1;
      er = (!trx() || rxq.size() < DEPTH) && (!ttx() || txq.size() < DEPTH);
      chk("R2 R3 sin_ready", {31'd0, sin_ready}, {31'd0, er});
      chk("R12 sout_valid", {31'd0, sout_valid}, {31'd0, txq.size() > 0});
      if (txq.size() > 0) chk("R1 R12 sout_data", {24'd0, sout_data}, {24'd0, txq[0]});
      chk("R11 irq", {31'd0, irq}, {31'd0, |(m_ist & m_mask)});
      if (bus_sel && !bus_we) begin
         case (int'(bus_addr))
            6: chk("R5 status", bus_rdata, exp_read(6));
            7: chk("R1 R6 data", bus_rdata, exp_read(7));
            3: chk("R4 R10 R11 istat", bus_rdata, exp_read(3));
            default: chk("R8 R9 regread", bus_rdata, exp_read(int'(bus_addr)));
         endcase
      end
      @(posedge clk);
      #1;
      model_step();
      @(negedge clk);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   task automatic wreg(int a, logic [31:0] d);
      bus_sel = 1; bus_we = 1; bus_addr = AW'(a); bus_wdata = d;
      cyc();
      bus_sel = 0; bus_we = 0; bus_wdata = '0;
   endtask

   task automatic rreg(int a);
      bus_sel = 1; bus_we = 0; bus_addr = AW'(a);
      cyc();
      bus_sel = 0;
   endtask

   task automatic sbyte(logic [7:0] d);
      sin_valid = 1; sin_data = d;
      cyc();
      sin_valid = 0;
   endtask

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R9 reset values
      rreg(0); rreg(1); rreg(2); rreg(3); rreg(4); rreg(6);
      wreg(0, 32'h114);          // receive and transmit enabled
      wreg(2, 32'h3);
      // R2 normal mode, R1 order, R6 pops
      sbyte(8'h11); sbyte(8'h22); sbyte(8'h33);
      rreg(7); rreg(6); rreg(7);
      // fill receive queue to 16, then overrun (R4, R3 ready low)
      for (int i = 0; i < 15; i++) sbyte(8'h40 + 8'(i));
      rreg(6);
      sbyte(8'hEE);
      rreg(3);
      wreg(3, 32'h1);            // R11 write-one-to-clear
      rreg(3);
      // R10 idle timeout after last accepted byte
      idle(TMO + 2);
      rreg(3);
      wreg(3, 32'h2);
      // R5 receive threshold variations
      wreg(4, 32'd16); rreg(6); wreg(4, 32'd17); rreg(6);
      for (int i = 0; i < 16; i++) rreg(7);
      rreg(7); rreg(6);
      // R6 receive disabled: pop ignored
      wreg(0, 32'h11C);
      sbyte(8'h5A);
      rreg(7); rreg(6);
      wreg(0, 32'h114);
      rreg(7);
      // R2 echo mode: both queues
      wreg(1, 32'd1);
      sbyte(8'hA1); sbyte(8'hA2);
      rreg(6);
      sout_ready = 1; idle(3); sout_ready = 0;
      rreg(7); rreg(7);
      // R2 remote loopback: transmit only, no overrun path
      wreg(1, 32'd3);
      sbyte(8'hB1);
      rreg(6);
      // R7 serial side wins over a data write in the same cycle
      sin_valid = 1; sin_data = 8'hB2;
      wreg(7, 32'h99);
      sin_valid = 0;
      sout_ready = 1; idle(3); sout_ready = 0;
      // R2 local loopback: accepted, stored nowhere
      wreg(1, 32'd2);
      sbyte(8'hC1);
      rreg(6);
      // R7 bus writes and gating
      wreg(1, 32'd0);
      wreg(7, 32'h77);
      wreg(0, 32'h134);          // transmit off
      wreg(7, 32'h88);
      rreg(6);
      wreg(0, 32'h114);
      for (int i = 0; i < 16; i++) wreg(7, 32'h60 + i);
      wreg(7, 32'hFF);           // full: dropped
      wreg(5, 32'd16); rreg(6);
      wreg(1, 32'd1);            // echo, transmit full -> ready low
      sbyte(8'hD1);
      rreg(6);
      sout_ready = 1; idle(2); sout_ready = 0;
      // R8 transmit clear, self-clearing bits
      wreg(0, 32'h116);
      rreg(6); rreg(0);
      // R8 receive clear
      wreg(1, 32'd0);
      sbyte(8'hE1); sbyte(8'hE2);
      wreg(0, 32'h115);
      rreg(6); rreg(7);
      // R9 unmapped indices
      rreg(8); rreg(17); rreg(18); rreg(63);
      // R11 mask gates irq
      wreg(2, 32'h0);
      for (int i = 0; i < 17; i++) sbyte(8'h10);
      rreg(3);
      wreg(2, 32'h1);
      idle(2);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(10 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule